// File: doc/BRIEF.md
# Link Transmit Character Selector

This block is the byte-rate front end of a serial link transmitter. On every rising edge of the byte clock it chooses one 10-bit character and registers it for an external serializer. The character can be an 8B/10B data character, an 8B/10B control character, the idle filler K28.5, a fixed violation symbol, a self-test character, or ten raw bits that bypass the encoder. Running disparity is tracked across all encoded characters.

User data is qualified by one of two active-low enables. `load_now_n` takes the byte present at the same edge. `load_next_n` takes the byte present at the edge after. A strobe forces the violation symbol. An active-low self-test input switches the source to an alternating 1-0 pattern or to a pseudo-random character stream. A raw-mode input turns the encoder off.

Top module: `link_char_sel`

## Requirements
- R1: While `rst_n` is low, `tx_char` is 0 and `tx_vld` is 0, and running disparity is negative. From the first clock edge after reset, `tx_vld` is 1 on every cycle. Inputs sampled at an edge determine the `tx_char` that appears right after that edge.
- R2: When `load_now_n` is low at an edge (encoder enabled, no violation, self-test off), `tx_char` is the 8B/10B encoding of `din`. `din[4:0]` is the 5-bit group and `din[7:5]` is the 3-bit group. `tx_char[9:0]` = {a,b,c,d,e,i,f,g,h,j}, with bit 9 sent first.
- R3: When `load_next_n` is low at edge N, the byte present at edge N+1 is encoded and sent at edge N+1. A load happens at an edge when either enable applies to it, and it happens only once even if both apply.
- R4: When no load applies (self-test off, no violation, encoder on), the data inputs are ignored and K28.5 is sent (001111 1010 at negative disparity, 110000 0101 at positive).
- R5: When `is_ctrl` is high on a load, the byte is encoded as a control character. The valid control characters are K28.0 to K28.7, K23.7, K27.7, K29.7 and K30.7. Any other byte sent with `is_ctrl` high produces the violation symbol.
- R6: Each 6-bit and 4-bit sub-block is chosen from the current running disparity. An unbalanced sub-block flips the disparity. The D.x.7 alternate code is used for x = 17, 18, 20 at negative disparity and for x = 11, 13, 14 at positive disparity. Every encoded character has 4, 5 or 6 ones.
- R7: When `send_viol` is high (encoder on), `tx_char` = 10'b1111110000 whatever the other inputs are, including self-test. Running disparity is unchanged.
- R8: When self-test is on (`bist_n` low) and no load applies, characters alternate D10.2, D21.5, and so on. After reset the first one is D10.2.
- R9: When self-test is on and a load applies, the data byte sent is `lfsr[7:0]` of a 9-bit LFSR. The LFSR starts at 9'h1FF after reset and then steps to {lfsr[7:0], lfsr[8]^lfsr[4]} (x^9+x^5+1).
- R10: When `send_viol` is high during self-test, the LFSR reloads 9'h1FF, so the next sequence character is again byte 8'hFF.
- R11: When `raw_mode` is high, `tx_char` = {din[7:0], is_ctrl, send_viol}. Running disparity and the LFSR are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 8 | Data byte |
| is_ctrl | input | 1 | Control-character select, high = K character |
| send_viol | input | 1 | Violation strobe |
| load_now_n | input | 1 | Active-low enable for the current edge |
| load_next_n | input | 1 | Active-low enable for the following edge |
| raw_mode | input | 1 | Encoder bypass |
| bist_n | input | 1 | Active-low self-test enable |
| tx_char | output | 10 | Character to the serializer |
| tx_vld | output | 1 | Character valid |

## Verification
The violation strobe and the self-test sequence can act in the same cycle. The strobe must win the output slot and also reload the generator. The bench provokes this by raising the strobe during self-test while a deferred load is pending, and expects the violation symbol followed by the character for byte 8'hFF. A second collision is a current-edge load landing on an edge that a deferred enable already qualified, which must produce exactly one data character.

// File: rtl/link_char_sel.sv
module link_char_sel #(
  parameter int LW = 9,
  parameter logic [LW-1:0] SEED = '1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] din,
  input  logic       is_ctrl,
  input  logic       send_viol,
  input  logic       load_now_n,
  input  logic       load_next_n,
  input  logic       raw_mode,
  input  logic       bist_n,
  output logic [9:0] tx_char,
  output logic       tx_vld
);
  localparam logic [9:0] VIOL = 10'b1111110000;

  logic          rd, rd_d, pend, alt, alt_d;
  logic [LW-1:0] lfsr, lfsr_d;
  logic [9:0]    code;
  logic [7:0]    eb;
  logic          ek, load, bist;

  assign load = ~load_now_n | pend;
  assign bist = ~bist_n;

  function automatic logic [5:0] six(input logic [4:0] x);
    case (x)
      5'd0:  six = 6'b100111; 5'd1:  six = 6'b011101; 5'd2:  six = 6'b101101; 5'd3:  six = 6'b110001;
      5'd4:  six = 6'b110101; 5'd5:  six = 6'b101001; 5'd6:  six = 6'b011001; 5'd7:  six = 6'b111000;
      5'd8:  six = 6'b111001; 5'd9:  six = 6'b100101; 5'd10: six = 6'b010101; 5'd11: six = 6'b110100;
      5'd12: six = 6'b001101; 5'd13: six = 6'b101100; 5'd14: six = 6'b011100; 5'd15: six = 6'b010111;
      5'd16: six = 6'b011011; 5'd17: six = 6'b100011; 5'd18: six = 6'b010011; 5'd19: six = 6'b110010;
      5'd20: six = 6'b001011; 5'd21: six = 6'b101010; 5'd22: six = 6'b011010; 5'd23: six = 6'b111010;
      5'd24: six = 6'b110011; 5'd25: six = 6'b100110; 5'd26: six = 6'b010110; 5'd27: six = 6'b110110;
      5'd28: six = 6'b001110; 5'd29: six = 6'b101110; 5'd30: six = 6'b011110; default: six = 6'b101011;
    endcase
  endfunction

  function automatic logic k_ok(input logic [7:0] b);
    k_ok = (b[4:0] == 5'd28) ||
           (b[7:5] == 3'd7 && (b[4:0] == 5'd23 || b[4:0] == 5'd27 || b[4:0] == 5'd29 || b[4:0] == 5'd30));
  endfunction

  function automatic logic [10:0] enc(input logic [7:0] b, input logic k, input logic r);
    logic [4:0] x; logic [2:0] y; logic [5:0] s6; logic [3:0] s4; logic r1, a7;
    x = b[4:0]; y = b[7:5];
    s6 = (k && x == 5'd28) ? 6'b001111 : six(x);
    r1 = ($countones(s6) != 3) ? ~r : r;
    if (r && ($countones(s6) != 3 || (!k && x == 5'd7))) s6 = ~s6;
    a7 = k || (!r1 && (x == 5'd17 || x == 5'd18 || x == 5'd20)) ||
               (r1 && (x == 5'd11 || x == 5'd13 || x == 5'd14));
    case (y)
      3'd0: s4 = 4'b1011;
      3'd1: s4 = k ? 4'b0110 : 4'b1001;
      3'd2: s4 = k ? 4'b1010 : 4'b0101;
      3'd3: s4 = 4'b1100;
      3'd4: s4 = 4'b1101;
      3'd5: s4 = k ? 4'b0101 : 4'b1010;
      3'd6: s4 = k ? 4'b1001 : 4'b0110;
      default: s4 = a7 ? 4'b0111 : 4'b1110;
    endcase
    enc[10] = ($countones(s4) != 2) ? ~r1 : r1;
    if (r1 && ($countones(s4) != 2 || y == 3'd3 || k)) s4 = ~s4;
    enc[9:0] = {s6, s4};
  endfunction

  always_comb begin
    rd_d = rd; lfsr_d = lfsr; alt_d = alt; eb = 8'hBC; ek = 1'b1; code = VIOL;
    if (raw_mode) begin
      code = {din, is_ctrl, send_viol};
    end else if (send_viol) begin
      if (bist) lfsr_d = SEED;
    end else begin
      if (bist && load) begin
        eb = lfsr[7:0]; ek = 1'b0; lfsr_d = {lfsr[LW-2:0], lfsr[LW-1] ^ lfsr[4]};
      end else if (bist) begin
        eb = alt ? 8'hB5 : 8'h4A; ek = 1'b0; alt_d = ~alt;
      end else if (load) begin
        eb = din; ek = is_ctrl;
      end
      if (!ek || k_ok(eb)) {rd_d, code} = enc(eb, ek, rd);
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_char <= '0; tx_vld <= 1'b0; rd <= 1'b0; pend <= 1'b0; alt <= 1'b0; lfsr <= SEED;
    end else begin
      tx_char <= code; tx_vld <= 1'b1; rd <= rd_d; pend <= ~load_next_n; alt <= alt_d; lfsr <= lfsr_d;
    end

  a_r1_vld: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> tx_vld);
  a_r4_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !raw_mode && !send_viol && bist_n && !load |=> tx_char == 10'b0011111010 || tx_char == 10'b1100000101);
  a_r5_badk: assert property (@(posedge clk) disable iff (!rst_n)
    !raw_mode && !send_viol && bist_n && load && is_ctrl && !k_ok(din) |=> tx_char == VIOL);
  a_r6_balance: assert property (@(posedge clk) disable iff (!rst_n)
    !raw_mode && !send_viol && (bist || !load || !is_ctrl || k_ok(din))
    |=> $countones(tx_char) >= 4 && $countones(tx_char) <= 6);
  a_r7_viol: assert property (@(posedge clk) disable iff (!rst_n) !raw_mode && send_viol |=> tx_char == VIOL);
  a_r7_rd_hold: assert property (@(posedge clk) disable iff (!rst_n) raw_mode || send_viol |=> $stable(rd));
  a_r10_reseed: assert property (@(posedge clk) disable iff (!rst_n)
    !raw_mode && send_viol && bist |=> lfsr == SEED);
  a_r11_raw: assert property (@(posedge clk) disable iff (!rst_n)
    raw_mode |=> tx_char == $past({din, is_ctrl, send_viol}) && $stable(lfsr));
endmodule

// File: tb/link_char_sel_test.sv
module link_char_sel_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] din = '0;
  logic is_ctrl = 0, send_viol = 0, load_now_n = 1, load_next_n = 1, raw_mode = 0, bist_n = 1;
  logic [9:0] tx_char;
  logic tx_vld;
  int checks = 0, fails = 0;
  bit done = 0;

  logic [9:0] exp_q[$];
  string tag_q[$];
  logic m_rd = 0, m_pend = 0, m_alt = 0;
  logic [8:0] m_lfsr = 9'h1FF;
  localparam logic [9:0] VIOL = 10'b1111110000;

  link_char_sel uut (.clk(clk), .rst_n(rst_n), .din(din), .is_ctrl(is_ctrl), .send_viol(send_viol),
    .load_now_n(load_now_n), .load_next_n(load_next_n), .raw_mode(raw_mode), .bist_n(bist_n),
    .tx_char(tx_char), .tx_vld(tx_vld));

  always #4 clk = ~clk;

  function automatic logic [5:0] d6(input int x);
    logic [5:0] t[32] = '{6'b100111,6'b011101,6'b101101,6'b110001,6'b110101,6'b101001,6'b011001,6'b111000,
                          6'b111001,6'b100101,6'b010101,6'b110100,6'b001101,6'b101100,6'b011100,6'b010111,
                          6'b011011,6'b100011,6'b010011,6'b110010,6'b001011,6'b101010,6'b011010,6'b111010,
                          6'b110011,6'b100110,6'b010110,6'b110110,6'b001110,6'b101110,6'b011110,6'b101011};
    return t[x];
  endfunction

  function automatic logic [9:0] model_enc(input logic [7:0] b, input logic k);
    int x = b[4:0], y = b[7:5];
    logic [5:0] m6; logic [3:0] m4;
    logic [3:0] dm[8] = '{4'b1011,4'b1001,4'b0101,4'b1100,4'b1101,4'b1010,4'b0110,4'b1110};
    logic [3:0] km[8] = '{4'b1011,4'b0110,4'b1010,4'b1100,4'b1101,4'b0101,4'b1001,4'b0111};
    m6 = (k && x == 28) ? 6'b001111 : d6(x);
    if (m_rd && ($countones(m6) != 3 || (!k && x == 7))) m6 = ~m6;
    if ($countones(m6) != 3) m_rd = ~m_rd;
    m4 = k ? km[y] : dm[y];
    if (!k && y == 7 && ((!m_rd && (x == 17 || x == 18 || x == 20)) || (m_rd && (x == 11 || x == 13 || x == 14))))
      m4 = 4'b0111;
    if (m_rd && ($countones(m4) != 2 || y == 3 || k)) m4 = ~m4;
    if ($countones(m4) != 2) m_rd = ~m_rd;
    return {m6, m4};
  endfunction

  task automatic drive(input logic [7:0] d, input logic c, v, nn, nx, rm, st, input string tag);
    logic [9:0] e; logic ld;
    din = d; is_ctrl = c; send_viol = v; load_now_n = nn; load_next_n = nx; raw_mode = rm; bist_n = st;
    ld = !nn || m_pend;
    if (rm) e = {d, c, v};
    else if (v) begin e = VIOL; if (!st) m_lfsr = 9'h1FF; end
    else if (!st && ld) begin e = model_enc(m_lfsr[7:0], 0); m_lfsr = {m_lfsr[7:0], m_lfsr[8] ^ m_lfsr[4]}; end
    else if (!st) begin e = model_enc(m_alt ? 8'hB5 : 8'h4A, 0); m_alt = !m_alt; end
    else if (ld) begin
      if (c && !(d[4:0] == 28 || (d[7:5] == 7 && d[4:0] inside {23, 27, 29, 30}))) e = VIOL;
      else e = model_enc(d, c);
    end else e = model_enc(8'hBC, 1);
    m_pend = !nx;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
  endtask

  always @(posedge clk) if (rst_n) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [9:0] e; string t;
      e = exp_q.pop_front(); t = tag_q.pop_front();
      checks++;
      if (tx_char !== e || tx_vld !== 1'b1) begin
        fails++;
        $display("FAIL %s/R1: tx_char=%b vld=%b expected %b vld=1", t, tx_char, tx_vld, e);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    checks++;
    if (tx_char !== 10'd0 || tx_vld !== 1'b0) begin
      fails++; $display("FAIL R1 reset: tx_char=%b vld=%b expected 0 vld=0", tx_char, tx_vld);
    end
    rst_n = 1'b1;
    drive(8'h00, 0, 0, 1, 1, 0, 1, "R4");
    drive(8'h00, 0, 0, 0, 1, 0, 1, "R2");
    drive(8'hF1, 0, 0, 0, 1, 0, 1, "R6");
    drive(8'hEB, 0, 0, 0, 1, 0, 1, "R6");
    drive(8'h63, 0, 0, 0, 1, 0, 1, "R6");
    drive(8'hED, 0, 0, 0, 1, 0, 1, "R6");
    for (int i = 0; i < 24; i++) drive(8'(i * 37 + 5), 0, 0, 0, 1, 0, 1, "R2");
    drive(8'hBC, 1, 0, 0, 1, 0, 1, "R5");
    drive(8'h3C, 1, 0, 0, 1, 0, 1, "R5");
    drive(8'hF7, 1, 0, 0, 1, 0, 1, "R5");
    drive(8'hFB, 1, 0, 0, 1, 0, 1, "R5");
    drive(8'hFC, 1, 0, 0, 1, 0, 1, "R5");
    drive(8'h00, 1, 0, 0, 1, 0, 1, "R5");
    drive(8'hFD, 1, 0, 0, 1, 0, 1, "R5");
    drive(8'h77, 0, 0, 1, 1, 0, 1, "R4");
    drive(8'h11, 0, 0, 1, 0, 0, 1, "R3");
    drive(8'h5A, 0, 0, 1, 1, 0, 1, "R3");
    drive(8'h22, 0, 0, 1, 1, 0, 1, "R3");
    drive(8'h33, 0, 0, 1, 0, 0, 1, "R3");
    drive(8'h44, 0, 0, 0, 1, 0, 1, "R3");
    drive(8'h55, 1, 1, 0, 1, 0, 1, "R7");
    drive(8'h0F, 0, 0, 0, 1, 0, 1, "R7");
    for (int i = 0; i < 4; i++) drive(8'hAA, 0, 0, 1, 1, 0, 0, "R8");
    for (int i = 0; i < 12; i++) drive(8'h00, 0, 0, 0, 1, 0, 0, "R9");
    drive(8'h00, 0, 1, 1, 0, 0, 0, "R10");
    drive(8'h00, 0, 0, 1, 1, 0, 0, "R10");
    for (int i = 0; i < 3; i++) drive(8'h00, 0, 0, 0, 1, 0, 0, "R10");
    drive(8'hA5, 1, 0, 1, 1, 1, 1, "R11");
    drive(8'h3C, 0, 1, 0, 1, 1, 0, "R11");
    drive(8'h00, 0, 0, 0, 1, 0, 0, "R11");
    drive(8'h07, 0, 0, 0, 1, 0, 1, "R11");
    drive(8'hBC, 0, 0, 1, 1, 0, 1, "R4");
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule